// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the word address a synchronous memory array uses on each cycle of a four-word burst. One externally supplied address starts a burst. On each following cycle a two-bit beat counter steps the two least significant address bits through four positions while the upper address bits stay fixed. After four positions the sequence returns to the first word.

A per-burst ordering choice picks one of two patterns for the low bits. The linear pattern adds the beat count to the starting low bits and wraps. The interleaved pattern XORs the beat count into the starting low bits. The ordering is captured together with the start address, so a change on the ordering pin during a burst only takes effect at the next load.

A stall input freezes every register. While it is high, load and advance requests are ignored. The address output is registered state, so it shows a new value in the cycle after the edge that accepted a load or an advance.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low and after its release until the first accepted request, `word_addr` is zero.
- R2: An edge with `stall` = 0 and `advance` = 0 is a load. After that edge, `word_addr` equals the `ext_addr` that was sampled, in both orderings.
- R3: With ordering bit 0 captured at the load (linear), the k-th accepted advance after the load (an edge with `stall` = 0 and `advance` = 1) gives `word_addr[1:0]` = (start low bits + k) mod 4.
- R4: With ordering bit 1 captured at the load (interleaved), the k-th accepted advance gives `word_addr[1:0]` = start low bits XOR (k mod 4).
- R5: The fourth accepted advance after a load brings `word_addr` back to the loaded start address, and later advances repeat the same four-word cycle.
- R6: Across accepted advances, `word_addr[ADDR_W-1:2]` does not change. Only a load can change the upper bits.
- R7: On an edge with `stall` = 1, neither a load nor an advance is accepted and `word_addr` holds. When `stall` drops, the sequence continues from the held beat.
- R8: `order_ilv` is used only on load edges. Changing it during advances does not alter the sequence of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | 1 freezes all state and ignores requests |
| advance | input | 1 | 0 loads a new start address, 1 steps the beat counter |
| order_ilv | input | 1 | Ordering sampled at load: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | Start address of a new burst |
| word_addr | output | ADDR_W | Address for the current burst cycle |

## Verification
The bench builds the block with `ADDR_W` = 6. This makes it possible to load every one of the 64 start addresses in both orderings and to follow each burst through five advances, so every starting low-bit value, every beat and the wrap back to the start are compared against arithmetic in the bench. During those advances the bench toggles the ordering pin and drives unrelated values on the address input, which exercises the per-burst capture and the fixed upper bits on every burst. Separate sequences hold the stall input high during a pending load and during a pending advance, and then resume the burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
    } beat_state_t;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o
);

    beat_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.beat = '0;
        end else if (step_i) begin
            state_d.beat = state_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign beat_o = state_q.beat;

    // R5: the counter wraps from the last beat back to zero
    assert_beat_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && beat_o == BEAT_W'(BEATS - 1)) |=> (beat_o == '0));

    // R7: without a request the counter holds its value
    assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(beat_o));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ilv_i,
    output logic [ADDR_W-1:0] base_o,
    output order_e            order_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        order_e            order;
    } base_state_t;

    base_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.base  = addr_i;
            state_d.order = ilv_i ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{base: '0, order: ORD_LINEAR};
        end else begin
            state_q <= state_d;
        end
    end

    assign base_o  = state_q.base;
    assign order_o = state_q.order;

    // R8: the captured ordering changes only on a load
    assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] base_i,
    input  order_e            order_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] start_lo;
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;
    logic [BEAT_W-1:0] sel_lo;

    assign start_lo = base_i[BEAT_W-1:0];
    assign lin_lo   = start_lo + beat_i;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_lo[b] = start_lo[b] ^ beat_i[b];
    end

    always_comb begin
        case (order_i)
            ORD_INTERLEAVE: sel_lo = ilv_lo;
            default:        sel_lo = lin_lo;
        endcase
    end

    assign addr_o = {base_i[ADDR_W-1 -: UPPER_W], sel_lo};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              advance,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] word_addr
);

    logic              load_req;
    logic              step_req;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] base;
    order_e            order;

    assign load_req = !stall && !advance;
    assign step_req = !stall && advance;

    burst_beat_ctr u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_req),
        .step_i (step_req),
        .beat_o (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_req),
        .addr_i  (ext_addr),
        .ilv_i   (order_ilv),
        .base_o  (base),
        .order_o (order)
    );

    burst_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base_i  (base),
        .order_i (order),
        .beat_i  (beat),
        .addr_o  (word_addr)
    );

    // R2: a load shows the external address on the next cycle
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !advance) |=> (word_addr == $past(ext_addr)));

    // R6: upper bits are unchanged by an advance
    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance) |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

    // R3: linear ordering steps the low bits by one
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && order == ORD_LINEAR)
        |=> (word_addr[BEAT_W-1:0] == BEAT_W'($past(word_addr[BEAT_W-1:0]) + 1'b1)));

    // R4: interleaved ordering always changes the low bits on an advance
    assert_ilv_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && advance && order == ORD_INTERLEAVE)
        |=> ($countones(word_addr[BEAT_W-1:0] ^ $past(word_addr[BEAT_W-1:0])) != 0));

    // R7: a stalled edge leaves the address unchanged
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(word_addr));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b1;
    logic          advance = 1'b1;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] word_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .advance   (advance),
        .order_ilv (order_ilv),
        .ext_addr  (ext_addr),
        .word_addr (word_addr)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic adv, input logic ilv, input logic [AW-1:0] a);
        stall = st; advance = adv; order_ilv = ilv; ext_addr = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input bit ilv, input int k);
        logic [1:0] lo;
        lo = ilv ? (s[1:0] ^ 2'(k % 4)) : 2'((s[1:0] + k) % 4);
        return {s[AW-1:2], lo};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", word_addr, '0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 6'd37);
        chk("R1 after release", word_addr, '0);

        // R2 R3 R4 R5 R6 R8: sweep every start in both orderings
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < (1 << AW); s++) begin
                cyc(1'b0, 1'b0, m[0], AW'(s));
                chk(m ? "R2 load ilv" : "R2 load lin", word_addr, AW'(s));
                for (int k = 1; k <= 5; k++) begin
                    cyc(1'b0, 1'b1, ~m[0] ^ k[0], AW'(s * 7 + k * 13));
                    if (k == 4)
                        chk("R5 wrap", word_addr, AW'(s));
                    else
                        chk(m ? "R4 R6 R8 ilv beat" : "R3 R6 R8 lin beat",
                            word_addr, expect_addr(AW'(s), m[0], k));
                end
            end
        end

        // R7: stall blocks a pending load and a pending advance
        for (int m = 0; m < 2; m++) begin
            cyc(1'b0, 1'b0, m[0], 6'd22);
            cyc(1'b0, 1'b1, m[0], 6'd0);
            chk("R7 pre-stall", word_addr, expect_addr(6'd22, m[0], 1));
            for (int i = 0; i < 3; i++) begin
                cyc(1'b1, 1'b0, ~m[0], 6'd51);
                chk("R7 stalled load", word_addr, expect_addr(6'd22, m[0], 1));
            end
            for (int i = 0; i < 3; i++) begin
                cyc(1'b1, 1'b1, m[0], 6'd51);
                chk("R7 stalled advance", word_addr, expect_addr(6'd22, m[0], 1));
            end
            cyc(1'b0, 1'b1, m[0], 6'd51);
            chk("R7 resume", word_addr, expect_addr(6'd22, m[0], 2));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule